// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources for an 8-bit CPU core: two active-low external request pins, two timer overflow events and a serial source formed from a receive flag and a transmit flag. Each source is gated by its own enable bit and by a global enable bit, and is placed at a high or low priority level by a priority byte. The block picks one winner and presents its fixed vector address to the core, together with a request line. Within a level the source with the lower vector wins.

The core answers with a one-cycle acknowledge. On that acknowledge the block clears the flags that hardware owns and records the level now in service. A one-cycle return pulse releases the most recently entered level. A high-level request can pre-empt a low-level routine. A low-level request waits until nothing is in service, and no request interrupts a routine of its own level. Software can set or clear any flag through per-flag pulse inputs, which has the same effect as a hardware event.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `irq_vector` is 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 for source index 0 (external 0), 1 (timer 0), 2 (external 1), 3 (timer 1) or 4 (serial), the same cycle that `irq_req` is high. While `irq_req` is low, `irq_vector` is 0x0000.
- R2: Among the requesting sources at the same level, the lowest source index wins.
- R3: `en_reg` bit i (i = 0..4) enables source index i. Bits 6 and 5 have no effect.
- R4: While `en_reg` bit 7 is 0, `irq_req` stays low whatever the other enable bits are.
- R5: `prio_reg` bit i (i = 0..4) set to 1 places source i at the high level. A high-level winner is chosen before any low-level source, whatever their indices.
- R6: With `ext_edge_mode[p]` = 1, a 1-to-0 change of `ext_pin_n[p]` sets the flag of external p (`flags` bit 2p) at the next clock edge. An acknowledged grant of that source clears the flag.
- R7: With `ext_edge_mode[p]` = 0, `flags` bit 2p equals the inverse of `ext_pin_n[p]` one clock later. Acknowledge and the software set and clear inputs have no effect on it.
- R8: A `tmr_ovf[p]` pulse sets `flags` bit 2p+1. An acknowledged grant of timer p clears it.
- R9: `ser_rx_set` and `ser_tx_set` set `flags` bits 4 and 5. The serial source requests while either flag is 1. An acknowledge never clears these flags; only `sw_clr` does.
- R10: `sw_set[i]` sets and `sw_clr[i]` clears `flags` bit i at the next edge, for the edge-mode external flags, the timer flags and the serial flags. When a set (hardware or software) and a clear fall on the same flag in one cycle, the set wins.
- R11: `in_service` bit 1 marks a high-level routine and bit 0 a low-level routine. A high-level request is offered only while bit 1 is 0. A low-level request is offered only while both bits are 0.
- R12: An `irq_ret` pulse clears `in_service` bit 1 if it is set, otherwise bit 0. With nothing in service, it has no effect.
- R13: `irq_ack` while `irq_req` is low changes no flag and no `in_service` bit.
- R14: After reset all flags are 0, `in_service` is 0, `irq_req` is 0 and `irq_vector` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_n | input | 2 | External request pins, active low, synchronous to clk |
| ext_edge_mode | input | 2 | 1: falling-edge capture, 0: flag follows pin level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx_set | input | 1 | Serial receive-complete pulse |
| ser_tx_set | input | 1 | Serial transmit-complete pulse |
| sw_set | input | 6 | Software set pulses, one per flag |
| sw_clr | input | 6 | Software clear pulses, one per flag |
| en_reg | input | 8 | Enable byte: bit 7 global, bits 4..0 per source |
| prio_reg | input | 8 | Priority byte: bits 4..0 per source, 1 is high |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | A vector is offered |
| irq_vector | output | 16 | Vector address of the winner |
| in_service | output | 2 | Bit 1 high level active, bit 0 low level active |
| flags | output | 6 | Request flags: ext0, tmr0, ext1, tmr1, rx, tx from bit 0 up |

## Verification
The assertions take the pins as already synchronous to the clock, and treat acknowledge, return and all set and clear inputs as single-cycle pulses sampled at the rising edge. They also take `irq_ack` to refer to the vector offered in that same cycle. The stimulus drives every input on the falling edge and lowers each pulse after one cycle. It raises acknowledge only as a pulse, whether or not a request is showing, so the ignored-acknowledge case is exercised under the same timing. Pin and mode changes come as single-cycle-aligned level changes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int N_PAIR        = 2;
    localparam int N_SRC         = 2 * N_PAIR + 1;
    localparam int N_FLAG        = N_SRC + 1;
    localparam int SRC_IDX_W     = $clog2(N_SRC);
    localparam int SRC_SER       = 2 * N_PAIR;
    localparam int FLAG_RX       = 2 * N_PAIR;
    localparam int FLAG_TX       = 2 * N_PAIR + 1;
    localparam int GLOBAL_EN_BIT = 7;
    localparam int LVL_LO        = 0;
    localparam int LVL_HI        = 1;

    typedef logic [SRC_IDX_W-1:0] src_idx_t;

    typedef struct packed {
        logic     valid;
        logic     hi;
        src_idx_t idx;
    } grant_t;

    function automatic src_idx_t lowest_set(input logic [N_SRC-1:0] v);
        src_idx_t r;
        r = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_idx_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PAIR-1:0] ext_pin_n,
    input  logic [N_PAIR-1:0] ext_edge_mode,
    input  logic [N_PAIR-1:0] tmr_ovf,
    input  logic              ser_rx_set,
    input  logic              ser_tx_set,
    input  logic [N_FLAG-1:0] sw_set,
    input  logic [N_FLAG-1:0] sw_clr,
    input  logic [N_FLAG-1:0] hw_clr,
    output logic [N_FLAG-1:0] flag_o,
    output logic [N_SRC-1:0]  pend_o
);

    typedef struct packed {
        logic [N_FLAG-1:0] flag;
        logic [N_PAIR-1:0] pin_prev;
        logic              live;
    } fb_state_t;

    fb_state_t st_d, st_q;

    logic [N_FLAG-1:0] hw_set;
    logic [N_FLAG-1:0] lvl_mask;
    logic [N_FLAG-1:0] lvl_val;
    logic [N_FLAG-1:0] held;

    always_comb begin
        hw_set   = '0;
        lvl_mask = '0;
        lvl_val  = '0;
        for (int p = 0; p < N_PAIR; p++) begin
            hw_set[2*p]     = ext_edge_mode[p] & st_q.pin_prev[p] & ~ext_pin_n[p];
            hw_set[2*p+1]   = tmr_ovf[p];
            lvl_mask[2*p]   = ~ext_edge_mode[p];
            lvl_val[2*p]    = ~ext_pin_n[p];
        end
        hw_set[FLAG_RX] = ser_rx_set;
        hw_set[FLAG_TX] = ser_tx_set;

        held = (st_q.flag & ~(sw_clr | hw_clr)) | hw_set | sw_set;

        st_d          = st_q;
        st_d.flag     = (lvl_mask & lvl_val) | (~lvl_mask & held);
        st_d.pin_prev = ext_pin_n;
        st_d.live     = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag     <= '0;
            st_q.pin_prev <= '1;
            st_q.live     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pend_o = '0;
        for (int p = 0; p < N_PAIR; p++) begin
            pend_o[2*p]   = st_q.flag[2*p];
            pend_o[2*p+1] = st_q.flag[2*p+1];
        end
        pend_o[SRC_SER] = st_q.flag[FLAG_RX] | st_q.flag[FLAG_TX];
    end

    assign flag_o = st_q.flag;

    // Serial flags drop only on a software clear
    assert_rx_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag[FLAG_RX]) |-> $past(sw_clr[FLAG_RX]))
        else $error("serial rx flag cleared without software");
    assert_tx_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag[FLAG_TX]) |-> $past(sw_clr[FLAG_TX]))
        else $error("serial tx flag cleared without software");

    for (genvar p = 0; p < N_PAIR; p++) begin : g_chk
        assert_tmr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.flag[2*p+1]) |-> $past(sw_clr[2*p+1] | hw_clr[2*p+1]))
            else $error("timer flag cleared without cause");
        assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.live && !$past(ext_edge_mode[p])) |-> (st_q.flag[2*p] == !$past(ext_pin_n[p])))
            else $error("level-mode flag does not follow pin");
        assert_edge_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.live && $past(ext_edge_mode[p]) && $rose(st_q.flag[2*p]))
                |-> $past(sw_set[2*p] | ~ext_pin_n[p]))
            else $error("edge-mode flag rose without cause");
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [7:0]       en_reg,
    input  logic [7:0]       prio_reg,
    input  logic [1:0]       insvc_i,
    output grant_t           grant_o
);

    logic [N_SRC-1:0] armed;
    logic [N_SRC-1:0] hi_set;
    logic [N_SRC-1:0] lo_set;

    always_comb begin
        armed  = pend_i & en_reg[N_SRC-1:0] & {N_SRC{en_reg[GLOBAL_EN_BIT]}};
        hi_set = armed & prio_reg[N_SRC-1:0];
        lo_set = armed & ~prio_reg[N_SRC-1:0];

        grant_o = '0;
        if ((hi_set != '0) && !insvc_i[LVL_HI]) begin
            grant_o.valid = 1'b1;
            grant_o.hi    = 1'b1;
            grant_o.idx   = lowest_set(hi_set);
        end else if ((lo_set != '0) && (insvc_i == 2'b00)) begin
            grant_o.valid = 1'b1;
            grant_o.hi    = 1'b0;
            grant_o.idx   = lowest_set(lo_set);
        end
    end

    assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o.valid |-> en_reg[GLOBAL_EN_BIT])
        else $error("grant with global enable off");
    assert_grant_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o.valid |-> (en_reg[grant_o.idx] && pend_i[grant_o.idx]))
        else $error("grant for a disabled or idle source");
    assert_level_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o.valid |-> (prio_reg[grant_o.idx] == grant_o.hi))
        else $error("grant level differs from priority bit");

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
    import irq_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_hi,
    input  logic       ret,
    output logic [1:0] insvc_o
);

    typedef struct packed {
        logic [1:0] insvc;
    } lt_state_t;

    lt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ret) begin
            if (st_q.insvc[LVL_HI]) st_d.insvc[LVL_HI] = 1'b0;
            else                    st_d.insvc[LVL_LO] = 1'b0;
        end
        if (take) begin
            if (take_hi) st_d.insvc[LVL_HI] = 1'b1;
            else         st_d.insvc[LVL_LO] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign insvc_o = st_q.insvc;

    assert_ret_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take && st_q.insvc[LVL_HI]) |=> (!st_q.insvc[LVL_HI] && $stable(st_q.insvc[LVL_LO])))
        else $error("return did not release the high level");
    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !ret) |=> $stable(st_q.insvc))
        else $error("service state moved without take or return");

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_pin_n,
    input  logic [1:0]       ext_edge_mode,
    input  logic [1:0]       tmr_ovf,
    input  logic             ser_rx_set,
    input  logic             ser_tx_set,
    input  logic [5:0]       sw_set,
    input  logic [5:0]       sw_clr,
    input  logic [7:0]       en_reg,
    input  logic [7:0]       prio_reg,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic [1:0]       in_service,
    output logic [5:0]       flags
);

    logic [N_FLAG-1:0] hw_clr;
    logic [N_SRC-1:0]  pend;
    logic [1:0]        insvc;
    logic              take;
    grant_t            grant;

    irq_flag_bank u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_pin_n     (ext_pin_n),
        .ext_edge_mode (ext_edge_mode),
        .tmr_ovf       (tmr_ovf),
        .ser_rx_set    (ser_rx_set),
        .ser_tx_set    (ser_tx_set),
        .sw_set        (sw_set),
        .sw_clr        (sw_clr),
        .hw_clr        (hw_clr),
        .flag_o        (flags),
        .pend_o        (pend)
    );

    irq_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .en_reg   (en_reg),
        .prio_reg (prio_reg),
        .insvc_i  (insvc),
        .grant_o  (grant)
    );

    irq_level_track u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .take_hi (grant.hi),
        .ret     (irq_ret),
        .insvc_o (insvc)
    );

    always_comb begin
        take   = irq_ack & grant.valid;
        hw_clr = '0;
        for (int p = 0; p < N_PAIR; p++) begin
            hw_clr[2*p]   = take && (grant.idx == src_idx_t'(2*p)) && ext_edge_mode[p];
            hw_clr[2*p+1] = take && (grant.idx == src_idx_t'(2*p+1));
        end
    end

    always_comb begin
        irq_vector = '0;
        if (grant.valid) begin
            irq_vector = VEC_W'(VEC_BASE) + VEC_W'(grant.idx) * VEC_W'(VEC_STEP);
        end
    end

    assign irq_req    = grant.valid;
    assign in_service = insvc;

    assert_hi_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !in_service[LVL_HI])
        else $error("request offered during high-level service");
    assert_lo_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !prio_reg[grant.idx]) |-> (in_service == 2'b00))
        else $error("low-level request offered during service");
    assert_ser_no_hwclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr[FLAG_RX] == 1'b0) && (hw_clr[FLAG_TX] == 1'b0))
        else $error("hardware clear reached a serial flag");
    assert_take_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !irq_ret) |=> (in_service != 2'b00))
        else $error("accepted request left nothing in service");

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  ext_edge_mode = 2'b11;
    logic [1:0]  tmr_ovf = '0;
    logic        ser_rx_set = 1'b0;
    logic        ser_tx_set = 1'b0;
    logic [5:0]  sw_set = '0;
    logic [5:0]  sw_clr = '0;
    logic [7:0]  en_reg = '0;
    logic [7:0]  prio_reg = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vector;
    logic [1:0]  in_service;
    logic [5:0]  flags;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
        .tmr_ovf(tmr_ovf), .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set),
        .sw_set(sw_set), .sw_clr(sw_clr), .en_reg(en_reg), .prio_reg(prio_reg),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
        .irq_vector(irq_vector), .in_service(in_service), .flags(flags)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_tag = "R14";
    bit    done = 1'b0;

    logic [5:0] m_flag = '0;
    logic [1:0] m_prev = 2'b11;
    logic [1:0] m_insvc = '0;

    function automatic void m_pick(output logic v, output logic hi, output int idx);
        logic [4:0] pend, armed, hs, ls;
        pend  = {m_flag[4] | m_flag[5], m_flag[3:0]};
        armed = pend & en_reg[4:0] & {5{en_reg[7]}};
        hs    = armed & prio_reg[4:0];
        ls    = armed & ~prio_reg[4:0];
        v = 1'b0; hi = 1'b0; idx = 0;
        if (hs != 0 && !m_insvc[1]) begin
            v = 1'b1; hi = 1'b1;
            for (int i = 4; i >= 0; i--) if (hs[i]) idx = i;
        end else if (ls != 0 && m_insvc == 2'b00) begin
            v = 1'b1;
            for (int i = 4; i >= 0; i--) if (ls[i]) idx = i;
        end
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic v, hi;
        int   idx;
        m_pick(v, hi, idx);
        check("irq_req", 32'(irq_req), 32'(v));
        check("irq_vector", 32'(irq_vector), v ? 32'(3 + 8 * idx) : 32'd0);
        check("flags", 32'(flags), 32'(m_flag));
        check("in_service", 32'(in_service), 32'(m_insvc));
    endtask

    // One clock: model next state from the inputs now driven, then compare
    task automatic cycle();
        logic v, hi, take;
        int   idx;
        logic [5:0] hc, nf;
        logic [1:0] ni;
        m_pick(v, hi, idx);
        take = irq_ack & v;
        hc = '0;
        nf = '0;
        for (int p = 0; p < 2; p++) begin
            hc[2*p]   = take && (idx == 2*p) && ext_edge_mode[p];
            hc[2*p+1] = take && (idx == 2*p+1);
            if (ext_edge_mode[p])
                nf[2*p] = (m_flag[2*p] & ~(sw_clr[2*p] | hc[2*p])) | (m_prev[p] & ~ext_pin_n[p]) | sw_set[2*p];
            else
                nf[2*p] = ~ext_pin_n[p];
            nf[2*p+1] = (m_flag[2*p+1] & ~(sw_clr[2*p+1] | hc[2*p+1])) | tmr_ovf[p] | sw_set[2*p+1];
        end
        nf[4] = (m_flag[4] & ~sw_clr[4]) | ser_rx_set | sw_set[4];
        nf[5] = (m_flag[5] & ~sw_clr[5]) | ser_tx_set | sw_set[5];
        ni = m_insvc;
        if (irq_ret) begin
            if (ni[1]) ni[1] = 1'b0;
            else       ni[0] = 1'b0;
        end
        if (take) ni[hi ? 1 : 0] = 1'b1;
        @(negedge clk);
        m_flag  = nf;
        m_prev  = ext_pin_n;
        m_insvc = ni;
        compare_all();
        tmr_ovf = '0; ser_rx_set = 1'b0; ser_tx_set = 1'b0;
        sw_set = '0; sw_clr = '0; irq_ack = 1'b0; irq_ret = 1'b0;
    endtask

    task automatic do_ack(); irq_ack = 1'b1; cycle(); endtask
    task automatic do_ret(); irq_ret = 1'b1; cycle(); endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R14: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R14 reset";
        compare_all();

        // R8 timer flag, vector R1, clear on acknowledge
        cur_tag = "R8 timer";
        en_reg = 8'h8A;
        tmr_ovf = 2'b01; cycle();
        cycle();
        do_ack();
        do_ret();
        tmr_ovf = 2'b10; cycle();
        do_ack();
        cur_tag = "R12 return";
        do_ret();
        do_ret();

        // R2 fixed order within the low level, R10 software set
        cur_tag = "R2 order";
        en_reg = 8'h9F;
        sw_set = 6'b001111; cycle();
        for (int k = 0; k < 4; k++) begin
            do_ack();
            cycle();
            do_ret();
        end

        // R4 global enable off, R13 acknowledge ignored
        cur_tag = "R4 global";
        en_reg = 8'h1F;
        sw_set = 6'b001111; cycle();
        cur_tag = "R13 stray ack";
        do_ack();
        cycle();

        // R3 bits 6 and 5 have no effect
        cur_tag = "R3 enables";
        en_reg = 8'hE0; cycle();
        en_reg = 8'h84; cycle();
        sw_clr = 6'b001111; cycle();

        // R5 high level beats a lower index
        cur_tag = "R5 priority";
        en_reg = 8'h9F; prio_reg = 8'h10;
        tmr_ovf = 2'b01; ser_rx_set = 1'b1; cycle();
        do_ack();
        // R9 serial flag kept after acknowledge
        cur_tag = "R9 serial";
        cycle();
        sw_clr = 6'b010000; do_ret();
        // R11 nesting: low taken, then high pre-empts, then blocked
        cur_tag = "R11 nesting";
        do_ack();
        cycle();
        ser_tx_set = 1'b1; cycle();
        do_ack();
        tmr_ovf = 2'b10; prio_reg = 8'h18; cycle();
        do_ret();
        do_ret();
        do_ret();
        do_ack();
        do_ret();
        sw_clr = 6'b111111; cycle();

        // R10 set wins over clear in one cycle
        cur_tag = "R10 set-clear";
        en_reg = 8'h00;
        sw_set = 6'b000010; sw_clr = 6'b000010; cycle();
        sw_clr = 6'b000010; cycle();
        sw_set = 6'b110000; cycle();
        sw_clr = 6'b110000; ser_rx_set = 1'b1; cycle();
        sw_clr = 6'b110000; cycle();

        // R7 level mode follows pin, ignores acknowledge and software
        cur_tag = "R7 level";
        en_reg = 8'h85; prio_reg = 8'h00;
        ext_edge_mode = 2'b00; cycle();
        ext_pin_n = 2'b10; cycle();
        do_ack();
        sw_clr = 6'b000001; cycle();
        do_ret();
        ext_pin_n = 2'b11; cycle();
        sw_set = 6'b000100; cycle();

        // R6 edge capture and clear, no re-capture while held low
        cur_tag = "R6 edge";
        ext_edge_mode = 2'b11; cycle();
        ext_pin_n = 2'b01; cycle();
        do_ack();
        cycle();
        ext_pin_n = 2'b11; do_ret();
        ext_pin_n = 2'b10; cycle();
        ext_pin_n = 2'b11; cycle();
        do_ack();
        do_ret();

        // Random mix across all requirements (R2 ordering dominates)
        cur_tag = "R2 random";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0) ext_pin_n[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 63) == 0) ext_edge_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 31) == 0) en_reg = 8'($urandom_range(0, 255)) | 8'h80;
            if ($urandom_range(0, 127) == 0) en_reg[7] = 1'b0;
            if ($urandom_range(0, 31) == 0) prio_reg = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 9) == 0) tmr_ovf = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 15) == 0) ser_rx_set = 1'b1;
            if ($urandom_range(0, 15) == 0) ser_tx_set = 1'b1;
            if ($urandom_range(0, 11) == 0) sw_set = 6'(1 << $urandom_range(0, 5));
            if ($urandom_range(0, 5) == 0)  sw_clr = 6'(1 << $urandom_range(0, 5));
            if ($urandom_range(0, 3) == 0)  irq_ack = 1'b1;
            if ($urandom_range(0, 4) == 0)  irq_ret = 1'b1;
            cycle();
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule